// File: doc/BRIEF.md
# I2C Serial Clock Phase Generator

This block produces the serial clock of an I2C bus master from a fast peripheral clock. A single unsigned control value C sets both phase lengths, and the selected speed mode sets their ratio. In standard (100 kHz class) mode the low and high phases are each C clocks long. In fast (400 kHz class) mode with the duty option cleared, the high phase is C clocks and the low phase is 2C. With the duty option set, they are 9C and 16C. The block pulls the line low or releases it, and it watches the real line level.

After it releases the line, the block does not begin timing the high phase at once. It waits for a programmed rise-time count to pass and for the line to be sampled high. A target that holds the clock low therefore stretches the cycle. A protocol engine sits beside the block and frames START, STOP and data with the help of two one-cycle strobes. One marks each point where the block starts driving low. The other marks each point where high-phase timing begins. The block runs only while it is enabled and while the stated peripheral clock frequency is legal for the selected mode. In every other case it leaves the line released.

Top module: `scl_clkgen`

## Requirements
- R1: Out of reset, and for as long as `enable` is low, `scl_drive_low`, `fall_strobe` and `rise_strobe` are all 0.
- R2: In standard mode (`fast_sel`=0, `duty_sel` ignored), the line is driven low for exactly C clocks, and the high phase, counted from the `rise_strobe` cycle, lasts exactly C clocks.
- R3: In fast mode with `duty_sel`=0, the low phase is 2C clocks and the high phase is C clocks.
- R4: In fast mode with `duty_sel`=1, the low phase is 16C clocks and the high phase is 9C clocks.
- R5: A control value below the mode minimum is treated as that minimum. The minimum is 4 in standard mode and 1 in fast mode, and a control value of 0 falls under this rule.
- R6: After the low phase ends, the released line is held in a rise-wait state before high timing begins. When the line already reads high, this wait lasts exactly `trise_val` clocks, and a `trise_val` of 0 counts as 1.
- R7: While the line reads low after release, the block stays in rise-wait with the line released and emits no `rise_strobe`. High timing begins on the clock edge at which the line is sampled high, provided the rise-time count has elapsed.
- R8: `fall_strobe` is high for exactly the first cycle of each low phase. `rise_strobe` is high for exactly the first cycle of each high phase. The two strobes are never high together.
- R9: The block runs only when `pfreq_mhz` is within 2..46 in standard mode or within 6..46 in fast mode. Outside that range it behaves as disabled.
- R10: When `enable` falls in the middle of a phase, the line is released and both strobes are 0 from the next cycle on. No further strobe follows while the block stays disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the clock generator |
| ccr_val | input | 12 | Clock-control value C |
| fast_sel | input | 1 | 1 selects fast mode |
| duty_sel | input | 1 | Fast-mode duty option (16:9 when 1) |
| pfreq_mhz | input | 6 | Peripheral clock frequency in MHz |
| trise_val | input | 6 | Rise-time wait in peripheral clocks |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_strobe | output | 1 | One-cycle pulse at the start of each low phase |
| rise_strobe | output | 1 | One-cycle pulse at the start of each high phase |

## Verification
The bench sweeps all three mode and duty combinations against control values from 0 up to just past the standard minimum, and against two rise-time settings. In each case it measures the low, rise-wait and high lengths of one full cycle. This sweep separates the three ratio formulas from one another, shows the clamp on the small values, and shows that the rise count adds only to the wait and never to the high phase. A line held low by a model target checks stretching. Frequency values on both sides of each legal bound show the guard. Dropping `enable` partway through a low phase shows how the block shuts down.

// File: rtl/scl_pkg.sv
// Shared types for the SCL phase generator.
// Assumes: used by all modules of scl_clkgen; no parameters of its own.
package scl_pkg;

    // Phase of the generated clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_RISE = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

endpackage

// File: rtl/scl_phase_calc.sv
// Derives the low and high phase lengths in peripheral clocks from the
// control value, the speed mode and the duty option.
// Assumes: CNT_W is wide enough to hold 16 times the largest control value.
module scl_phase_calc #(
    parameter int CCR_W    = 12,
    parameter int CNT_W    = CCR_W + 5,
    parameter int MIN_STD  = 4,
    parameter int MIN_FAST = 1
) (
    input  logic [CCR_W-1:0] ccr_val,
    input  logic             fast_sel,
    input  logic             duty_sel,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] high_len
);

    localparam logic [CCR_W-1:0] FLOOR_STD  = CCR_W'(MIN_STD);
    localparam logic [CCR_W-1:0] FLOOR_FAST = CCR_W'(MIN_FAST);

    logic [CCR_W-1:0] floor_val;
    logic [CCR_W-1:0] unit_val;
    logic [CNT_W-1:0] unit_w;

    // Clamp the control value to the minimum for the current mode.
    always_comb begin
        floor_val = fast_sel ? FLOOR_FAST : FLOOR_STD;
        unit_val  = (ccr_val < floor_val) ? floor_val : ccr_val;
        unit_w    = CNT_W'(unit_val);
    end

    // Scale the unit by the mode ratio: 1:1, 2:1 or 16:9 (low:high).
    always_comb begin
        unique case ({fast_sel, duty_sel})
            2'b10: begin
                low_len  = unit_w << 1;
                high_len = unit_w;
            end
            2'b11: begin
                low_len  = unit_w << 4;
                high_len = (unit_w << 3) + unit_w;
            end
            default: begin
                low_len  = unit_w;
                high_len = unit_w;
            end
        endcase
    end

endmodule

// File: rtl/scl_freq_guard.sv
// Allows the generator to run only when the stated peripheral frequency is
// inside the legal window for the selected speed mode.
// Assumes: pfreq_mhz is static while running; it is evaluated every cycle.
module scl_freq_guard #(
    parameter int FREQ_W    = 6,
    parameter int FMIN_STD  = 2,
    parameter int FMIN_FAST = 6,
    parameter int FMAX      = 46
) (
    input  logic              enable,
    input  logic              fast_sel,
    input  logic [FREQ_W-1:0] pfreq_mhz,
    output logic              run_ok
);

    localparam logic [FREQ_W-1:0] LO_STD  = FREQ_W'(FMIN_STD);
    localparam logic [FREQ_W-1:0] LO_FAST = FREQ_W'(FMIN_FAST);
    localparam logic [FREQ_W-1:0] HI_ALL  = FREQ_W'(FMAX);

    logic [FREQ_W-1:0] lo_bound;

    // Combine the enable with the mode-dependent frequency window.
    always_comb begin
        lo_bound = fast_sel ? LO_FAST : LO_STD;
        run_ok   = enable && (pfreq_mhz >= lo_bound) && (pfreq_mhz <= HI_ALL);
    end

endmodule

// File: rtl/scl_phase_fsm.sv
// Sequences idle, low, rise-wait and high phases, drives the line low during
// the low phase and raises a one-cycle strobe at the start of low and high.
// Assumes: phase lengths are at least 1; scl_in is already synchronised.
module scl_phase_fsm
    import scl_pkg::*;
#(
    parameter int CNT_W = 17,
    parameter int TR_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_ok,
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    input  logic [TR_W-1:0]  trise_val,
    input  logic             scl_in,
    output logic             drive_low,
    output logic             fall_stb,
    output logic             rise_stb
);

    localparam logic [TR_W-1:0]  TR_ONE  = TR_W'(1);
    localparam logic [TR_W-1:0]  TR_MAX  = {TR_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TR_W-1:0]  rcnt_q;
    logic             fall_q;
    logic             rise_q;
    logic [TR_W-1:0]  tr_eff;
    logic [TR_W-1:0]  tr_last;
    logic             rise_done;

    // Rise-wait ends once the count has elapsed and the line reads high.
    always_comb begin
        tr_eff    = (trise_val == '0) ? TR_ONE : trise_val;
        tr_last   = tr_eff - TR_ONE;
        rise_done = (rcnt_q >= tr_last) && scl_in;
    end

    // Phase sequencing, phase counters and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            rcnt_q  <= '0;
            fall_q  <= 1'b0;
            rise_q  <= 1'b0;
        end else begin
            fall_q <= 1'b0;
            rise_q <= 1'b0;
            if (!run_ok) begin
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
                rcnt_q  <= '0;
            end else begin
                unique case (phase_q)
                    PH_IDLE: begin
                        phase_q <= PH_LOW;
                        cnt_q   <= low_len - CNT_ONE;
                        fall_q  <= 1'b1;
                    end
                    PH_LOW: begin
                        if (cnt_q == '0) begin
                            phase_q <= PH_RISE;
                            rcnt_q  <= '0;
                        end else begin
                            cnt_q <= cnt_q - CNT_ONE;
                        end
                    end
                    PH_RISE: begin
                        if (rise_done) begin
                            phase_q <= PH_HIGH;
                            cnt_q   <= high_len - CNT_ONE;
                            rise_q  <= 1'b1;
                        end else if (rcnt_q != TR_MAX) begin
                            rcnt_q <= rcnt_q + TR_ONE;
                        end
                    end
                    PH_HIGH: begin
                        if (cnt_q == '0) begin
                            phase_q <= PH_LOW;
                            cnt_q   <= low_len - CNT_ONE;
                            fall_q  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - CNT_ONE;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    // Outputs come straight from registered state.
    always_comb begin
        drive_low = (phase_q == PH_LOW);
        fall_stb  = fall_q;
        rise_stb  = rise_q;
    end

endmodule

// File: rtl/scl_clkgen.sv
// Top level of the SCL phase generator: phase length calculator, frequency
// guard and phase sequencer.
// Assumes: scl_in is synchronised to clk outside this block; configuration
// changes take effect at the next phase start.
module scl_clkgen #(
    parameter int CCR_W     = 12,
    parameter int FREQ_W    = 6,
    parameter int TR_W      = 6,
    parameter int MIN_STD   = 4,
    parameter int MIN_FAST  = 1,
    parameter int FMIN_STD  = 2,
    parameter int FMIN_FAST = 6,
    parameter int FMAX      = 46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CCR_W-1:0]  ccr_val,
    input  logic              fast_sel,
    input  logic              duty_sel,
    input  logic [FREQ_W-1:0] pfreq_mhz,
    input  logic [TR_W-1:0]   trise_val,
    input  logic              scl_in,
    output logic              scl_drive_low,
    output logic              fall_strobe,
    output logic              rise_strobe
);

    localparam int CNT_W = CCR_W + 5;

    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] high_len;
    logic             run_ok;

    scl_phase_calc #(
        .CCR_W    (CCR_W),
        .CNT_W    (CNT_W),
        .MIN_STD  (MIN_STD),
        .MIN_FAST (MIN_FAST)
    ) u_calc (
        .ccr_val  (ccr_val),
        .fast_sel (fast_sel),
        .duty_sel (duty_sel),
        .low_len  (low_len),
        .high_len (high_len)
    );

    scl_freq_guard #(
        .FREQ_W    (FREQ_W),
        .FMIN_STD  (FMIN_STD),
        .FMIN_FAST (FMIN_FAST),
        .FMAX      (FMAX)
    ) u_guard (
        .enable    (enable),
        .fast_sel  (fast_sel),
        .pfreq_mhz (pfreq_mhz),
        .run_ok    (run_ok)
    );

    scl_phase_fsm #(
        .CNT_W (CNT_W),
        .TR_W  (TR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_ok    (run_ok),
        .low_len   (low_len),
        .high_len  (high_len),
        .trise_val (trise_val),
        .scl_in    (scl_in),
        .drive_low (scl_drive_low),
        .fall_stb  (fall_strobe),
        .rise_stb  (rise_strobe)
    );

endmodule

// File: rtl/scl_clkgen_chk.sv
// Port-level temporal checks on scl_clkgen, attached with bind.
// Assumes: synchronous active-low reset on rst_n.
module scl_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_in,
    input logic scl_drive_low,
    input logic fall_strobe,
    input logic rise_strobe
);

    // R8: strobes never coincide.
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_strobe && rise_strobe));

    // R8: the fall strobe lasts one cycle.
    assert_fall_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_strobe |=> !fall_strobe);

    // R8: the rise strobe lasts one cycle.
    assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_strobe |=> !rise_strobe);

    // R8: a fall strobe coincides with the line being driven low.
    assert_fall_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_strobe |-> scl_drive_low);

    // R7: high timing begins only with the line released and reading high.
    assert_rise_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_strobe |-> (!scl_drive_low && scl_in));

    // R6: a rise strobe is always preceded by a released cycle.
    assert_rise_after_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_strobe |-> !$past(scl_drive_low));

    // R10: after enable is seen low, the line is released with no strobes.
    assert_disable_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !fall_strobe && !rise_strobe));

endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .fall_strobe   (fall_strobe),
    .rise_strobe   (rise_strobe)
);

// File: tb/scl_clkgen_bench.sv
// Self-checking bench for scl_clkgen: sweeps modes, control values and
// rise-time settings and measures each phase length at the ports.
module scl_clkgen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [11:0] ccr_val = '0;
    logic        fast_sel = 1'b0;
    logic        duty_sel = 1'b0;
    logic [5:0]  pfreq_mhz = 6'd8;
    logic [5:0]  trise_val = 6'd1;
    logic        hold_low = 1'b0;
    logic        scl_line;
    logic        scl_drive_low;
    logic        fall_strobe;
    logic        rise_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    // Open-drain line model: low if the block or a target pulls it.
    assign scl_line = !(scl_drive_low || hold_low);

    scl_clkgen u_scl_clkgen (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .ccr_val       (ccr_val),
        .fast_sel      (fast_sel),
        .duty_sel      (duty_sel),
        .pfreq_mhz     (pfreq_mhz),
        .trise_val     (trise_val),
        .scl_in        (scl_line),
        .scl_drive_low (scl_drive_low),
        .fall_strobe   (fall_strobe),
        .rise_strobe   (rise_strobe)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Measure one full cycle: low length, rise-wait length, high length.
    task automatic measure(output int lo, output int rw, output int hi,
                           output int nf, output int nr);
        int g;
        g = 0; lo = 0; rw = 0; hi = 0; nf = 0; nr = 0;
        @(negedge clk);
        while (!fall_strobe && g < 4000) begin @(negedge clk); g++; end
        while (scl_drive_low && g < 4000) begin
            if (fall_strobe) nf++;
            lo++; @(negedge clk); g++;
        end
        while (!rise_strobe && g < 4000) begin rw++; @(negedge clk); g++; end
        while (!fall_strobe && g < 4000) begin
            if (rise_strobe) nr++;
            hi++; @(negedge clk); g++;
        end
    endtask

    // Enable from idle and report whether a fall strobe appears.
    task automatic probe_run(output bit seen);
        seen = 1'b0;
        @(negedge clk); enable = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (fall_strobe) seen = 1'b1;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int lo, rw, hi, nf, nr, c, cm, eh, el, tr;
        bit seen;
        string tag;

        // R1: reset state.
        repeat (4) @(negedge clk);
        check_eq("R1", "drive in reset", int'(scl_drive_low), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R1", "drive while disabled", int'(scl_drive_low), 0);
        check_eq("R1", "strobes while disabled", int'(fall_strobe | rise_strobe), 0);

        // R2..R6, R8: sweep of mode, control value and rise time.
        enable = 1'b1;
        for (int m = 0; m < 3; m++) begin
            for (int ci = 0; ci < 7; ci++) begin
                for (int ti = 0; ti < 2; ti++) begin
                    c  = (ci == 6) ? 7 : ci;
                    tr = (ti == 0) ? 0 : 3;
                    @(negedge clk);
                    fast_sel  = (m != 0);
                    duty_sel  = (m == 2);
                    ccr_val   = 12'(c);
                    trise_val = 6'(tr);
                    if (m == 0) begin
                        cm = (c < 4) ? 4 : c; el = cm; eh = cm; tag = "R2";
                    end else if (m == 1) begin
                        cm = (c < 1) ? 1 : c; el = 2 * cm; eh = cm; tag = "R3";
                    end else begin
                        cm = (c < 1) ? 1 : c; el = 16 * cm; eh = 9 * cm; tag = "R4";
                    end
                    if (cm != c) tag = {tag, "/R5"};
                    measure(lo, rw, hi, nf, nr);
                    check_eq(tag, $sformatf("low m%0d c%0d", m, c), lo, el);
                    check_eq(tag, $sformatf("high m%0d c%0d", m, c), hi, eh);
                    check_eq("R6", $sformatf("rise wait m%0d c%0d t%0d", m, c, tr), rw, (tr == 0) ? 1 : tr);
                    check_eq("R8", "fall strobes per low", nf, 1);
                    check_eq("R8", "rise strobes per high", nr, 1);
                end
            end
        end

        // R7: target holds the line low for 10 cycles after release.
        @(negedge clk);
        fast_sel = 1'b0; duty_sel = 1'b0; ccr_val = 12'd6; trise_val = 6'd3;
        begin
            int g, cnt, drv, rs;
            g = 0; cnt = 0; drv = 0; rs = 0;
            while (!fall_strobe && g < 2000) begin @(negedge clk); g++; end
            hold_low = 1'b1;
            while (scl_drive_low && g < 2000) begin @(negedge clk); g++; end
            while (!rise_strobe && g < 2000) begin
                if (scl_drive_low) drv++;
                cnt++;
                if (cnt == 10) hold_low = 1'b0;
                @(negedge clk); g++;
            end
            check_eq("R7", "stretched wait length", cnt, 10);
            check_eq("R7", "drive during stretch", drv, 0);
            measure(lo, rw, hi, nf, nr);
            check_eq("R7", "low after stretch", lo, 6);
            check_eq("R7", "high after stretch", hi, 6);
        end

        // R10: disable in the middle of a low phase.
        @(negedge clk);
        fast_sel = 1'b1; duty_sel = 1'b1; ccr_val = 12'd2;
        begin
            int g, act;
            g = 0; act = 0;
            while (!fall_strobe && g < 2000) begin @(negedge clk); g++; end
            @(negedge clk);
            @(negedge clk);
            enable = 1'b0;
            @(negedge clk);
            check_eq("R10", "drive one cycle after disable", int'(scl_drive_low), 0);
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (scl_drive_low || fall_strobe || rise_strobe) act++;
            end
            check_eq("R10", "activity while disabled", act, 0);
        end

        // R9: frequency window on each side of each bound.
        fast_sel = 1'b0; duty_sel = 1'b0; ccr_val = 12'd4; trise_val = 6'd1;
        pfreq_mhz = 6'd1;  probe_run(seen); check_eq("R9", "std 1 MHz runs", int'(seen), 0);
        pfreq_mhz = 6'd2;  probe_run(seen); check_eq("R9", "std 2 MHz runs", int'(seen), 1);
        pfreq_mhz = 6'd46; probe_run(seen); check_eq("R9", "std 46 MHz runs", int'(seen), 1);
        pfreq_mhz = 6'd47; probe_run(seen); check_eq("R9", "std 47 MHz runs", int'(seen), 0);
        fast_sel = 1'b1;
        pfreq_mhz = 6'd5;  probe_run(seen); check_eq("R9", "fast 5 MHz runs", int'(seen), 0);
        pfreq_mhz = 6'd6;  probe_run(seen); check_eq("R9", "fast 6 MHz runs", int'(seen), 1);
        pfreq_mhz = 6'd47; probe_run(seen); check_eq("R9", "fast 47 MHz runs", int'(seen), 0);
        check_eq("R9", "drive with bad frequency", int'(scl_drive_low), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule